// File: doc/BRIEF.md
# Instruction Decode Slot Grouper

This block sits between a buffer of predecoded, variable-length instructions and a two-wide decode stage. Each incoming record carries an instruction's byte length, which was worked out byte by byte earlier and stored with the instruction bytes. It also carries a two-bit class hint and an opaque payload. The block sorts every instruction into one of three decode classes: short, long or vector. Each clock it forms one decode group: two short instructions together, one long instruction alone, or one vector instruction alone. The oldest instruction always goes in slot 0.

Records enter through a valid/ready stream and wait in a small circular holding buffer. A record is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the buffer is not full, and it does not depend on `in_valid`. The output group is held in a register. Downstream accepts the whole group on an edge where `s0_valid` and `out_ready` are both high. While `s0_valid` is high and `out_ready` is low, the group stays unchanged and nothing leaves the buffer. The register loads a new group, possibly an empty one, whenever it is empty or its group is being accepted. The block then removes from the buffer exactly as many records as it placed in slots.

Top module: `decode_slot_grouper`

## Requirements
- R1: An instruction whose hint bit 1 is set is tagged vector (class code 2), whatever its length.
- R2: If hint bit 1 is clear, an instruction is tagged long (class code 1) when hint bit 0 is set or its length exceeds SHORT_MAX (7). Otherwise it is tagged short (class code 0). A length of 7 is short and a length of 8 is long.
- R3: When the two oldest buffered instructions are both short, both are issued in one group: the older one in slot 0 and the younger one in slot 1.
- R4: A long or vector instruction is issued alone in slot 0, and slot 1 is invalid.
- R5: A short instruction is issued alone when the next instruction is not short or has not yet been accepted into the buffer.
- R6: The records leave in exactly the order they were accepted, with none lost and none duplicated. `s1_valid` is never high without `s0_valid`.
- R7: While `s0_valid` is high and `out_ready` is low, every output stays stable and no record leaves the buffer.
- R8: The buffer holds DEPTH (4) records, and `in_ready` is low exactly when the buffer is full. With the output stalled and input offered continuously from reset, exactly DEPTH plus one records are accepted: four in the buffer and one in the output group.
- R9: A record accepted on edge t can enter a group loaded on edge t+1 or later. A group register that is free to load stays empty only if no record is waiting.
- R10: A synchronous reset empties the buffer and clears both slot valid flags, leaving `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Buffer can accept a record |
| in_len | input | LEN_W (4) | Instruction length in bytes |
| in_hint | input | 2 | Class hint: bit 1 vector, bit 0 long |
| in_data | input | DATA_W (16) | Opaque instruction payload |
| out_ready | input | 1 | Downstream accepts the current group |
| s0_valid | output | 1 | Slot 0 holds an instruction |
| s0_class | output | 2 | Slot 0 class: 0 short, 1 long, 2 vector |
| s0_len | output | LEN_W (4) | Slot 0 length |
| s0_hint | output | 2 | Slot 0 hint |
| s0_data | output | DATA_W (16) | Slot 0 payload |
| s1_valid | output | 1 | Slot 1 holds a second short instruction |
| s1_class | output | 2 | Slot 1 class |
| s1_len | output | LEN_W (4) | Slot 1 length |
| s1_hint | output | 2 | Slot 1 hint |
| s1_data | output | DATA_W (16) | Slot 1 payload |

## Verification
The grouping is tried with directed runs of short–short pairs, short–long and short–vector neighbours, and lengths of 7 and 8 on both sides of the short limit. These separate correct pairing from pairing that is too eager or too shy. A stalled fill from reset shows whether the buffer depth and the ready signal agree. A short instruction whose partner arrives one cycle late shows whether pairing waits for data it does not have. Long constrained-random runs with sparse input and random backpressure check ordering, stall stability and the rule that a free group register is never left empty while work is waiting. A mid-run reset checks that the buffer is emptied.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  typedef enum logic [1:0] {
    CLS_SHORT  = 2'd0,
    CLS_LONG   = 2'd1,
    CLS_VECTOR = 2'd2
  } grp_class_e;

  localparam int HINT_LONG_BIT = 0;
  localparam int HINT_VEC_BIT  = 1;
endpackage

// File: rtl/dsg_classify.sv
module dsg_classify #(
  parameter int LEN_W     = 4,
  parameter int SHORT_MAX = 7
) (
  input  logic [LEN_W-1:0]       len,
  input  logic [1:0]             hint,
  output dsg_pkg::grp_class_e    cls
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(SHORT_MAX);

  always_comb begin
    if (hint[dsg_pkg::HINT_VEC_BIT])
      cls = dsg_pkg::CLS_VECTOR;
    else if (hint[dsg_pkg::HINT_LONG_BIT] || (len > LIMIT))
      cls = dsg_pkg::CLS_LONG;
    else
      cls = dsg_pkg::CLS_SHORT;
  end
endmodule

// File: rtl/dsg_queue.sv
module dsg_queue #(
  parameter int REC_W = 22,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [REC_W-1:0] push_rec,
  input  logic [1:0]       pop_cnt,
  output logic             full,
  output logic [1:0]       have,
  output logic [REC_W-1:0] head0,
  output logic [REC_W-1:0] head1
);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q;

  assign full    = (count_q == FULL_CNT);
  assign have[0] = (count_q != '0);
  assign have[1] = (count_q > CNT_W'(1));
  assign head0   = mem[rd_ptr];
  assign head1   = mem[PTR_W'(rd_ptr + PTR_W'(1))];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wr_ptr + PTR_W'(1));
      rd_ptr  <= PTR_W'(rd_ptr + PTR_W'(pop_cnt));
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop_cnt);
    end
  end
endmodule

// File: rtl/dsg_pick.sv
module dsg_pick (
  input  logic [1:0]          have,
  input  dsg_pkg::grp_class_e cls0,
  input  dsg_pkg::grp_class_e cls1,
  output logic [1:0]          issue_cnt
);
  always_comb begin
    if (!have[0])
      issue_cnt = 2'd0;
    else if (cls0 == dsg_pkg::CLS_SHORT && have[1] && cls1 == dsg_pkg::CLS_SHORT)
      issue_cnt = 2'd2;
    else
      issue_cnt = 2'd1;
  end
endmodule

// File: rtl/decode_slot_grouper.sv
module decode_slot_grouper #(
  parameter int LEN_W     = 4,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 4,
  parameter int SHORT_MAX = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [1:0]        in_hint,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              s0_valid,
  output logic [1:0]        s0_class,
  output logic [LEN_W-1:0]  s0_len,
  output logic [1:0]        s0_hint,
  output logic [DATA_W-1:0] s0_data,
  output logic              s1_valid,
  output logic [1:0]        s1_class,
  output logic [LEN_W-1:0]  s1_len,
  output logic [1:0]        s1_hint,
  output logic [DATA_W-1:0] s1_data
);
  localparam int REC_W = LEN_W + 2 + DATA_W;

  logic                full;
  logic                push;
  logic [1:0]          have;
  logic [REC_W-1:0]    head [2];
  dsg_pkg::grp_class_e head_cls [2];
  logic [1:0]          issue_cnt;
  logic [1:0]          pop_cnt;
  logic                load;

  logic [REC_W-1:0]    slot_rec [2];
  dsg_pkg::grp_class_e slot_cls [2];
  logic [1:0]          slot_vld;

  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign load     = !slot_vld[0] || out_ready;
  assign pop_cnt  = load ? issue_cnt : 2'd0;

  dsg_queue #(.REC_W(REC_W), .DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_rec ({in_len, in_hint, in_data}),
    .pop_cnt  (pop_cnt),
    .full     (full),
    .have     (have),
    .head0    (head[0]),
    .head1    (head[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_cls
    dsg_classify #(.LEN_W(LEN_W), .SHORT_MAX(SHORT_MAX)) u_cls (
      .len  (head[g][REC_W-1 -: LEN_W]),
      .hint (head[g][DATA_W +: 2]),
      .cls  (head_cls[g])
    );
  end

  dsg_pick u_pick (
    .have      (have),
    .cls0      (head_cls[0]),
    .cls1      (head_cls[1]),
    .issue_cnt (issue_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
      for (int i = 0; i < 2; i++) begin
        slot_rec[i] <= '0;
        slot_cls[i] <= dsg_pkg::CLS_SHORT;
      end
    end else if (load) begin
      slot_vld[0] <= (issue_cnt != 2'd0);
      slot_vld[1] <= (issue_cnt == 2'd2);
      for (int i = 0; i < 2; i++) begin
        slot_rec[i] <= head[i];
        slot_cls[i] <= head_cls[i];
      end
    end
  end

  assign s0_valid = slot_vld[0];
  assign s0_class = slot_cls[0];
  assign s0_len   = slot_rec[0][REC_W-1 -: LEN_W];
  assign s0_hint  = slot_rec[0][DATA_W +: 2];
  assign s0_data  = slot_rec[0][DATA_W-1:0];
  assign s1_valid = slot_vld[1];
  assign s1_class = slot_cls[1];
  assign s1_len   = slot_rec[1][REC_W-1 -: LEN_W];
  assign s1_hint  = slot_rec[1][DATA_W +: 2];
  assign s1_data  = slot_rec[1][DATA_W-1:0];
endmodule

// File: rtl/dsg_checker.sv
module dsg_checker #(
  parameter int LEN_W     = 4,
  parameter int DATA_W    = 16,
  parameter int SHORT_MAX = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              out_ready,
  input logic              s0_valid,
  input logic [1:0]        s0_class,
  input logic [LEN_W-1:0]  s0_len,
  input logic [1:0]        s0_hint,
  input logic [DATA_W-1:0] s0_data,
  input logic              s1_valid,
  input logic [1:0]        s1_class,
  input logic [LEN_W-1:0]  s1_len,
  input logic [1:0]        s1_hint,
  input logic [DATA_W-1:0] s1_data
);
  p_vector_hint_r1: assert property (@(posedge clk) disable iff (rst)
    s0_valid && s0_hint[1] |-> s0_class == 2'd2);

  p_short_len_r2: assert property (@(posedge clk) disable iff (rst)
    s0_valid && s0_class == 2'd0 |-> s0_len <= LEN_W'(SHORT_MAX) && s0_hint == 2'd0);

  p_pair_short_r3: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> s0_class == 2'd0 && s1_class == 2'd0 && s1_len <= LEN_W'(SHORT_MAX));

  p_big_alone_r4: assert property (@(posedge clk) disable iff (rst)
    s0_valid && s0_class != 2'd0 |-> !s1_valid);

  p_slot_order_r6: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> s0_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    s0_valid && !out_ready |=> $stable(s0_valid) && $stable(s1_valid) && $stable(s0_data)
      && $stable(s1_data) && $stable(s0_class) && $stable(s1_class) && $stable(s1_hint));
endmodule

bind decode_slot_grouper dsg_checker #(
  .LEN_W(LEN_W), .DATA_W(DATA_W), .SHORT_MAX(SHORT_MAX)
) u_chk (
  .clk(clk), .rst(rst), .out_ready(out_ready),
  .s0_valid(s0_valid), .s0_class(s0_class), .s0_len(s0_len), .s0_hint(s0_hint), .s0_data(s0_data),
  .s1_valid(s1_valid), .s1_class(s1_class), .s1_len(s1_len), .s1_hint(s1_hint), .s1_data(s1_data)
);

// File: tb/decode_slot_grouper_tb.sv
`timescale 1ns/1ps
module decode_slot_grouper_tb;
  localparam int LEN_W = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH = 4;
  localparam int SHORT_MAX = 7;
  localparam int REC_W = LEN_W + 2 + DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [LEN_W-1:0] in_len = '0;
  logic [1:0] in_hint = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic s0_valid, s1_valid;
  logic [1:0] s0_class, s1_class, s0_hint, s1_hint;
  logic [LEN_W-1:0] s0_len, s1_len;
  logic [DATA_W-1:0] s0_data, s1_data;

  always #2 clk = ~clk;

  decode_slot_grouper #(.LEN_W(LEN_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .SHORT_MAX(SHORT_MAX)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_len(in_len), .in_hint(in_hint), .in_data(in_data), .out_ready(out_ready),
    .s0_valid(s0_valid), .s0_class(s0_class), .s0_len(s0_len), .s0_hint(s0_hint), .s0_data(s0_data),
    .s1_valid(s1_valid), .s1_class(s1_class), .s1_len(s1_len), .s1_hint(s1_hint), .s1_data(s1_data)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int n_pushed = 0;
  logic [DATA_W-1:0] seq = '0;
  logic [REC_W-1:0] mq[$];
  int mq_cyc[$];
  bit prev_take = 1'b1;
  logic [2*DATA_W+10:0] prev_out;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_class(input logic [LEN_W-1:0] l, input logic [1:0] h);
    if (h[1]) return 2'd2;
    if (h[0] || l > LEN_W'(SHORT_MAX)) return 2'd1;
    return 2'd0;
  endfunction

  function automatic string cls_req(input logic [1:0] h);
    return h[1] ? "R1" : "R2";
  endfunction

  function automatic logic [2*DATA_W+10:0] out_snap();
    return {s0_valid, s1_valid, s0_class, s1_class, s0_hint, s1_hint, s0_data, s1_data, 1'b0};
  endfunction

  task automatic observe();
    logic [REC_W-1:0] f, g;
    logic [1:0] fc;
    bit exp_pair;
    if (prev_take) begin
      if (s0_valid) begin
        if (mq.size() == 0) begin
          chk(1'b0, "R6", "group with no pending record", 1, 0);
        end else begin
          f = mq.pop_front();
          void'(mq_cyc.pop_front());
          fc = exp_class(f[REC_W-1 -: LEN_W], f[DATA_W +: 2]);
          chk(s0_data == f[DATA_W-1:0], "R6", "slot0 payload order", s0_data, f[DATA_W-1:0]);
          chk(s0_class == fc, cls_req(f[DATA_W +: 2]), "slot0 class", s0_class, fc);
          exp_pair = (fc == 2'd0) && (mq.size() > 0) && (mq_cyc[0] < cyc)
                     && (exp_class(mq[0][REC_W-1 -: LEN_W], mq[0][DATA_W +: 2]) == 2'd0);
          if (fc != 2'd0) chk(s1_valid == 1'b0, "R4", "big instr alone", s1_valid, 0);
          else if (exp_pair) chk(s1_valid == 1'b1, "R3", "short pair", s1_valid, 1);
          else chk(s1_valid == 1'b0, "R5", "short alone", s1_valid, 0);
          if (s1_valid && exp_pair) begin
            g = mq.pop_front();
            void'(mq_cyc.pop_front());
            chk(s1_data == g[DATA_W-1:0], "R6", "slot1 payload order", s1_data, g[DATA_W-1:0]);
            chk(s1_class == 2'd0, "R3", "slot1 class", s1_class, 0);
          end
        end
      end else begin
        chk(!(mq.size() > 0 && mq_cyc[0] < cyc), "R9", "empty group while work waits",
            int'(s1_valid), 0);
      end
    end else begin
      chk(out_snap() == prev_out, "R7", "stalled group changed", int'(s0_data), int'(prev_out[DATA_W+1 +: DATA_W]));
    end
  endtask

  task automatic step(input bit iv, input logic [LEN_W-1:0] l, input logic [1:0] h, input bit ordy);
    bit will_push;
    @(negedge clk);
    observe();
    prev_out = out_snap();
    in_valid = iv;
    in_len = l;
    in_hint = h;
    in_data = seq;
    out_ready = ordy;
    #1;
    will_push = in_valid && in_ready;
    prev_take = !s0_valid || out_ready;
    @(posedge clk);
    cyc++;
    if (will_push) begin
      mq.push_back({l, h, seq});
      mq_cyc.push_back(cyc);
      seq++;
      n_pushed++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(s0_valid == 1'b0 && s1_valid == 1'b0, "R10", "valids after reset", int'({s0_valid, s1_valid}), 0);
    chk(in_ready == 1'b1, "R10", "ready after reset", in_ready, 1);
    rst = 1'b0;
    mq.delete();
    mq_cyc.delete();
    prev_take = 1'b1;
    @(posedge clk);
    cyc++;
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R8: stalled fill from reset accepts DEPTH+1 records
    n_pushed = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 4'd9, 2'd0, 1'b0);
    chk(n_pushed == DEPTH + 1, "R8", "records accepted while stalled", n_pushed, DEPTH + 1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R8", "ready low when full", in_ready, 0);
    step(1'b0, 4'd0, 2'd0, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, 4'd0, 2'd0, 1'b1);
    chk(mq.size() == 0, "R6", "all stalled records drained", mq.size(), 0);

    // R10: mid-run reset with a filled buffer
    for (int i = 0; i < 6; i++) step(1'b1, 4'd3, 2'd0, 1'b0);
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 2'd0, 1'b1);
    chk(s0_valid == 1'b0, "R10", "buffer empty after reset", s0_valid, 0);

    // Directed patterns, buffered while stalled then released (R2/R3/R4/R5 boundaries)
    step(1'b1, 4'd7, 2'd0, 1'b0);  // short at limit
    step(1'b1, 4'd2, 2'd0, 1'b0);  // short
    step(1'b1, 4'd8, 2'd0, 1'b0);  // long by length
    step(1'b1, 4'd1, 2'd0, 1'b0);  // short
    step(1'b1, 4'd3, 2'd2, 1'b0);  // vector
    for (int i = 0; i < 6; i++) step(1'b0, 4'd0, 2'd0, 1'b1);
    step(1'b1, 4'd2, 2'd0, 1'b1);  // short then vector-hint short length
    step(1'b1, 4'd1, 2'd3, 1'b1);
    step(1'b1, 4'd4, 2'd1, 1'b1);  // long by hint
    step(1'b1, 4'd5, 2'd0, 1'b1);
    step(1'b0, 4'd0, 2'd0, 1'b1);
    step(1'b1, 4'd6, 2'd0, 1'b1);  // R5: partner arrives late
    for (int i = 0; i < 6; i++) step(1'b0, 4'd0, 2'd0, 1'b1);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [LEN_W-1:0] l;
      logic [1:0] h;
      int r;
      l = ($urandom % 10 < 6) ? LEN_W'(1 + $urandom % 7) : LEN_W'(8 + $urandom % 8);
      r = $urandom % 8;
      h = (r < 5) ? 2'd0 : (r == 5) ? 2'd1 : 2'd2 | 2'($urandom % 2);
      step(($urandom % 10) < ((i / 1000) % 2 == 0 ? 8 : 4), l, h, ($urandom % 10) < ((i / 500) % 2 == 0 ? 7 : 3));
    end
    for (int i = 0; i < 12; i++) step(1'b0, 4'd0, 2'd0, 1'b1);
    chk(mq.size() == 0, "R6", "no record lost", mq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule